// File: doc/BRIEF.md
# DVFS Operating-Point Transition Sequencer

This block moves one clock/voltage domain between up to four operating points. Each point has an index from 0 to 3, and a higher index means more performance. Each index maps to a frequency code and a voltage code, held in a small table that can be rewritten while the block is idle. Software asks for a new index. The block reads that index's codes from the table. It then drives a regulator request channel and a clock-generator request channel one step at a time. Each step waits for that channel's own completion handshake before the next step starts.

The order of the two steps depends on the direction of the move. When performance goes up, the voltage rises first and the frequency follows only after the regulator reports settled. When performance goes down, the frequency drops first and the voltage follows only after the clock generator reports locked. If a wait runs past a programmable cycle limit, the transition is abandoned and the domain keeps its last committed level. A request that arrives while a transition is running is dropped and flagged.

The state machine has six states:
- `ST_IDLE`: waits for a request.
- `ST_VOLT_UP`: the raise path's voltage step.
- `ST_FREQ_UP`: the raise path's frequency step.
- `ST_FREQ_DN`: the lower path's frequency step.
- `ST_VOLT_DN`: the lower path's voltage step.
- `ST_DONE`: a one-cycle completion state.

Its transitions are:
- IDLE→VOLT_UP when the requested index is higher than the current one.
- IDLE→FREQ_DN when the requested index is lower.
- IDLE→DONE when the requested index equals the current one.
- VOLT_UP→FREQ_UP on settled.
- FREQ_UP→DONE on locked.
- FREQ_DN→VOLT_DN on locked.
- VOLT_DN→DONE on settled.
- Any wait state→IDLE on timeout.
- DONE→IDLE unconditionally.

Top module: `dvfs_seq`

## Requirements
- R1: On a request with a higher index than `cur_level`, the block first raises `vreg_req` with `vreg_code` set to the target's voltage code. It raises `clk_req`, with `clk_code` set to the target's frequency code, only after `vreg_settled` has been seen high.
- R2: On a request with a lower index, the block first raises `clk_req` with the target's frequency code. It raises `vreg_req` with the target's voltage code only after `clk_locked` has been seen high.
- R3: A request equal to `cur_level` asserts `done` on the following cycle and raises neither `vreg_req` nor `clk_req`.
- R4: `cur_level` changes only in the cycle in which `done` is high, which is after both steps have completed. `done` lasts exactly one cycle.
- R5: A request presented while `busy` is high is ignored: the running transition ends at its own target. The request also sets the sticky flag `err_busy`, which stays set until `err_clr` is pulsed.
- R6: If a handshake wait lasts more than `tmo_limit`+1 cycles, the block returns to idle without asserting `done`. In that case it sets the sticky flag `err_tmo` and leaves `cur_level` at its previous value. `err_clr` clears the flag.
- R7: A table write (`cfg_we`, `cfg_idx`, `cfg_freq`, `cfg_volt`) takes effect only while `busy` is low. Writes made while busy are discarded.
- R8: After reset, the block is in this state:
  - `cur_level` is 0 and `busy`, `done`, both request lines and both error flags are low.
  - Entry i of the table holds frequency code 32·(i+1) and voltage code 64+16·i.
  - `clk_code` is 0x20 and `vreg_code` is 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_level | input | 2 | Requested operating-point index |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 2 | Table entry to write |
| cfg_freq | input | 8 | Frequency code to write |
| cfg_volt | input | 8 | Voltage code to write |
| tmo_limit | input | 24 | Handshake wait limit in cycles |
| err_clr | input | 1 | Clears both sticky error flags |
| vreg_req | output | 1 | Regulator request, held until settled |
| vreg_code | output | 8 | Voltage code presented to the regulator |
| vreg_settled | input | 1 | Regulator output has settled |
| clk_req | output | 1 | Clock-generator request, held until locked |
| clk_code | output | 8 | Frequency code presented to the clock generator |
| clk_locked | input | 1 | Clock generator has locked |
| busy | output | 1 | A transition is in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_level | output | 2 | Last committed operating-point index |
| err_busy | output | 1 | Sticky: a request arrived while busy |
| err_tmo | output | 1 | Sticky: a handshake wait timed out |

## Verification
The embedded assertions check several rules on every cycle:
- Step ordering: the frequency request never rises on a raise without a preceding settled, and the voltage request never rises on a lower without a preceding lock.
- `cur_level` moves only alongside `done`.
- The table holds still while a transition runs.
- A busy-time request always raises `err_busy`.
- A timeout flag rises only as the block goes idle.

The bench's scenarios are what show the rest:
- the actual code values reaching each channel;
- the direction chosen for each pair of levels;
- that a dropped request or a discarded table write leaves no trace on later transitions;
- that a timed-out raise keeps the old level and never produces `done`.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VOLT_UP,
        ST_FREQ_UP,
        ST_FREQ_DN,
        ST_VOLT_DN,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/dvfs_opp_table.sv
module dvfs_opp_table #(
    parameter int LEVELS = 4,
    parameter int FW     = 8,
    parameter int VW     = 8,
    localparam int IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_allow,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [FW-1:0] wr_freq,
    input  logic [VW-1:0] wr_volt,
    input  logic [IW-1:0] rd_idx,
    output logic [FW-1:0] rd_freq,
    output logic [VW-1:0] rd_volt
);
    logic [FW-1:0] freq_q [LEVELS];
    logic [VW-1:0] volt_q [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_entry
        localparam logic [FW-1:0] FRST = FW'(32 * (g + 1));
        localparam logic [VW-1:0] VRST = VW'(64 + 16 * g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                freq_q[g] <= FRST;
                volt_q[g] <= VRST;
            end else if (wr_en && wr_allow && (wr_idx == IW'(g))) begin
                freq_q[g] <= wr_freq;
                volt_q[g] <= wr_volt;
            end
        end

        AST_TABLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_allow |=> $stable(freq_q[g]) && $stable(volt_q[g])); // R7
    end

    always_comb begin
        rd_freq = freq_q[0];
        rd_volt = volt_q[0];
        for (int i = 0; i < LEVELS; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_freq = freq_q[i];
                rd_volt = volt_q[i];
            end
        end
    end
endmodule

// File: rtl/dvfs_wait_timer.sv
module dvfs_wait_timer #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || restart)
            cnt_q <= '0;
        else if (cnt_q != limit)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int FW     = 8,
    parameter int VW     = 8,
    parameter int TW     = 24,
    localparam int IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [IW-1:0] req_level,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [FW-1:0] cfg_freq,
    input  logic [VW-1:0] cfg_volt,
    input  logic [TW-1:0] tmo_limit,
    input  logic          err_clr,
    output logic          vreg_req,
    output logic [VW-1:0] vreg_code,
    input  logic          vreg_settled,
    output logic          clk_req,
    output logic [FW-1:0] clk_code,
    input  logic          clk_locked,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] cur_level,
    output logic          err_busy,
    output logic          err_tmo
);
    localparam logic [FW-1:0] FREQ0 = FW'(32);
    localparam logic [VW-1:0] VOLT0 = VW'(64);

    seq_state_e    state_q, state_d;
    logic [IW-1:0] tgt_q;
    logic [FW-1:0] tgt_freq_q, tbl_freq;
    logic [VW-1:0] tgt_volt_q, tbl_volt;
    logic          up_q;
    logic          waiting, step_ok, restart, expired, accept, commit, abort;

    dvfs_opp_table #(.LEVELS(LEVELS), .FW(FW), .VW(VW)) i_table (
        .clk(clk), .rst_n(rst_n),
        .wr_allow(state_q == ST_IDLE),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_freq(cfg_freq), .wr_volt(cfg_volt),
        .rd_idx(req_level), .rd_freq(tbl_freq), .rd_volt(tbl_volt)
    );

    dvfs_wait_timer #(.TW(TW)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .run(waiting), .restart(restart), .limit(tmo_limit), .expired(expired)
    );

    always_comb begin
        waiting = 1'b0;
        step_ok = 1'b0;
        unique case (state_q)
            ST_VOLT_UP, ST_VOLT_DN: begin waiting = 1'b1; step_ok = vreg_settled; end
            ST_FREQ_UP, ST_FREQ_DN: begin waiting = 1'b1; step_ok = clk_locked;   end
            default: ;
        endcase
    end

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign restart = step_ok && ((state_q == ST_VOLT_UP) || (state_q == ST_FREQ_DN));
    assign commit  = step_ok && ((state_q == ST_FREQ_UP) || (state_q == ST_VOLT_DN));
    assign abort   = waiting && !step_ok && expired;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_level == cur_level)     state_d = ST_DONE;
                    else if (req_level > cur_level) state_d = ST_VOLT_UP;
                    else                            state_d = ST_FREQ_DN;
                end
            end
            ST_VOLT_UP: state_d = step_ok ? ST_FREQ_UP : (expired ? ST_IDLE : ST_VOLT_UP);
            ST_FREQ_UP: state_d = step_ok ? ST_DONE    : (expired ? ST_IDLE : ST_FREQ_UP);
            ST_FREQ_DN: state_d = step_ok ? ST_VOLT_DN : (expired ? ST_IDLE : ST_FREQ_DN);
            ST_VOLT_DN: state_d = step_ok ? ST_DONE    : (expired ? ST_IDLE : ST_VOLT_DN);
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        vreg_req = 1'b0;
        clk_req  = 1'b0;
        done     = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE:                busy     = 1'b0;
            ST_VOLT_UP, ST_VOLT_DN: vreg_req = 1'b1;
            ST_FREQ_UP, ST_FREQ_DN: clk_req  = 1'b1;
            ST_DONE:                done     = 1'b1;
            default: ;
        endcase
    end

    // datapath: target, codes, committed level, sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q      <= '0;
            tgt_freq_q <= FREQ0;
            tgt_volt_q <= VOLT0;
            up_q       <= 1'b0;
            vreg_code  <= VOLT0;
            clk_code   <= FREQ0;
            cur_level  <= '0;
            err_busy   <= 1'b0;
            err_tmo    <= 1'b0;
        end else begin
            if (accept) begin
                tgt_q      <= req_level;
                tgt_freq_q <= tbl_freq;
                tgt_volt_q <= tbl_volt;
                up_q       <= (req_level > cur_level);
                if (req_level > cur_level)      vreg_code <= tbl_volt;
                else if (req_level < cur_level) clk_code  <= tbl_freq;
            end
            if (restart) begin
                if (up_q) clk_code  <= tgt_freq_q;
                else      vreg_code <= tgt_volt_q;
            end
            if (commit) cur_level <= tgt_q;

            if (req_valid && busy) err_busy <= 1'b1;
            else if (err_clr)      err_busy <= 1'b0;
            if (abort)             err_tmo  <= 1'b1;
            else if (err_clr)      err_tmo  <= 1'b0;
        end
    end

    AST_RAISE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_req) && up_q) |-> $past(vreg_settled)); // R1
    AST_LOWER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vreg_req) && !up_q) |-> $past(clk_locked)); // R2
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vreg_req && clk_req)); // R1
    AST_LEVEL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_level) |-> done); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> err_busy); // R5
    AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_tmo) |-> (!busy && $stable(cur_level))); // R6
endmodule

// File: tb/test_dvfs_seq.sv
module test_dvfs_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_level = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [7:0]  cfg_freq = '0;
    logic [7:0]  cfg_volt = '0;
    logic [23:0] tmo_limit = 24'd1000;
    logic        err_clr = 1'b0;
    logic        vreg_req, clk_req, busy, done, err_busy, err_tmo;
    logic [7:0]  vreg_code, clk_code;
    logic        vreg_settled = 1'b0;
    logic        clk_locked = 1'b0;
    logic [1:0]  cur_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] m_freq [4];
    logic [7:0] m_volt [4];
    logic [1:0] m_level;

    // responder for both handshake channels
    bit v_en = 1'b1, c_en = 1'b1;
    int v_dly = 3, c_dly = 3, v_cnt = 0, c_cnt = 0;
    int first_ch = 0;   // 0 none, 1 voltage, 2 frequency
    bit saw_done;

    dvfs_seq i_dvfs_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_freq(cfg_freq), .cfg_volt(cfg_volt),
        .tmo_limit(tmo_limit), .err_clr(err_clr),
        .vreg_req(vreg_req), .vreg_code(vreg_code), .vreg_settled(vreg_settled),
        .clk_req(clk_req), .clk_code(clk_code), .clk_locked(clk_locked),
        .busy(busy), .done(done), .cur_level(cur_level),
        .err_busy(err_busy), .err_tmo(err_tmo)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (vreg_req && v_en) begin
            v_cnt++;
            vreg_settled <= (v_cnt >= v_dly);
        end else begin
            v_cnt = 0;
            vreg_settled <= 1'b0;
        end
        if (clk_req && c_en) begin
            c_cnt++;
            clk_locked <= (c_cnt >= c_dly);
        end else begin
            c_cnt = 0;
            clk_locked <= 1'b0;
        end
        if (first_ch == 0 && vreg_req) first_ch = 1;
        if (first_ch == 0 && clk_req)  first_ch = 2;
    end

    // entry: [3:2] target level, [1:0] expected first channel
    localparam logic [3:0] VEC [7] = '{
        {2'd2, 2'd1}, {2'd3, 2'd1}, {2'd3, 2'd0}, {2'd1, 2'd2},
        {2'd0, 2'd2}, {2'd3, 2'd1}, {2'd2, 2'd2}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] lvl);
        first_ch = 0;
        saw_done = 1'b0;
        req_level = lvl;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            if (done) saw_done = 1'b1;
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic cfg_write(input logic [1:0] idx, input logic [7:0] f, input logic [7:0] v);
        cfg_idx = idx; cfg_freq = f; cfg_volt = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_freq[i] = 8'(32 * (i + 1));
            m_volt[i] = 8'(64 + 16 * i);
        end
        m_level = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        check("R8 cur_level", cur_level, 0);
        check("R8 busy", busy, 0);
        check("R8 done", done, 0);
        check("R8 requests", {vreg_req, clk_req}, 0);
        check("R8 errors", {err_busy, err_tmo}, 0);
        check("R8 vreg_code", vreg_code, 8'h40);
        check("R8 clk_code", clk_code, 8'h20);

        // vector walk: R1 raise order, R2 lower order, R3 same level, R4 commit
        foreach (VEC[n]) begin
            logic [1:0] lvl;
            int ord;
            lvl = VEC[n][3:2];
            ord = int'(VEC[n][1:0]);
            do_req(lvl);
            check(ord == 1 ? "R1 order" : (ord == 2 ? "R2 order" : "R3 no channel"), first_ch, ord);
            check("R4 done seen", saw_done, 1);
            check("R4 cur_level", cur_level, lvl);
            check("R1/R2 clk_code", clk_code, m_freq[lvl]);
            check("R1/R2 vreg_code", vreg_code, m_volt[lvl]);
            m_level = lvl;
        end
        @(negedge clk);
        check("R4 done one cycle", done, 0);

        // R7 idle write takes effect (now at level 2)
        cfg_write(2'd1, 8'h11, 8'h22);
        m_freq[1] = 8'h11; m_volt[1] = 8'h22;
        do_req(2'd1);
        check("R7 idle write freq", clk_code, 8'h11);
        check("R7 idle write volt", vreg_code, 8'h22);
        check("R2 order after write", first_ch, 2);

        // R5 request while busy, R7 write while busy
        v_dly = 15; c_dly = 15;
        first_ch = 0;
        req_level = 2'd3; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        req_level = 2'd0; req_valid = 1'b1;
        cfg_idx = 2'd0; cfg_freq = 8'hEE; cfg_volt = 8'hDD; cfg_we = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R5 ignored request level", cur_level, 3);
        check("R5 still idle", busy, 0);
        check("R5 err_busy set", err_busy, 1);
        v_dly = 3; c_dly = 3;
        do_req(2'd0);
        check("R7 busy write discarded freq", clk_code, m_freq[0]);
        check("R7 busy write discarded volt", vreg_code, m_volt[0]);
        check("R5 err_busy sticky", err_busy, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R5 err_clr", err_busy, 0);

        // R6 timeout on the raise voltage step
        tmo_limit = 24'd6;
        v_en = 1'b0;
        do_req(2'd3);
        check("R6 no done", saw_done, 0);
        check("R6 err_tmo", err_tmo, 1);
        check("R6 level held", cur_level, 0);
        check("R6 freq untouched", clk_code, m_freq[0]);
        // R6 timeout on the lower frequency step
        v_en = 1'b1;
        tmo_limit = 24'd1000;
        do_req(2'd2);
        check("R6 recovery level", cur_level, 2);
        tmo_limit = 24'd4;
        c_en = 1'b0;
        do_req(2'd0);
        check("R6 lower no done", saw_done, 0);
        check("R6 lower level held", cur_level, 2);
        check("R6 lower volt untouched", vreg_code, m_volt[2]);
        c_en = 1'b1;
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R6 err_clr", err_tmo, 0);

        finish_run();
    end
endmodule